// File: doc/BRIEF.md
# Floating-Point Operand Exception Screener

This block examines the source operands of a floating-point add or subtract before the arithmetic unit consumes them. Each operand, single or double precision, is sorted into zero, normal, infinity, subnormal, quiet NaN or signaling NaN. The class decides how the 32-bit control/status word changes and whether the operation must trap or may go ahead.

One issue cycle presents the operands, a precision select, a one-or-two-source select and the current control/status word, qualified by a valid strobe. One cycle later the block returns the rewritten control/status word together with exactly one of two pulses. `pass_o` lets the operation proceed. `trap_o` requests a floating-point exception.

The first source is always screened before the second. A trap raised by the first source ends the screening, so the second source is never looked at.

Top module: `fpu_opnd_screen`

## Requirements
- R1: In single precision only bits 31:0 of an operand are examined: exponent in bits 30:23, fraction in bits 22:0, and fraction bit 22 set marks a NaN as quiet. Bits 63:32 have no effect.
- R2: In double precision the exponent is bits 62:52 and the fraction is bits 51:0, with fraction bit 51 set marking a NaN as quiet. An all-ones exponent with a nonzero fraction is a NaN. A zero exponent with a nonzero fraction is subnormal.
- R3: The cause field (bits 17:12: inexact 12, underflow 13, overflow 14, divide-by-zero 15, invalid 16, unimplemented 17) is cleared at the start of each operation. All bits outside the cause field and the invalid flag (bit 6) are returned unchanged.
- R4: A subnormal operand sets cause bit 17 and traps, whatever the enable bits 11:7 hold.
- R5: A signaling-NaN operand sets cause bit 17 and traps.
- R6: A quiet-NaN operand sets cause bit 16. When the invalid enable (bit 11) is set, it traps and leaves flag bit 6 as it was.
- R7: A quiet-NaN operand with bit 11 clear sets cause bit 16 and sticky flag bit 6, and screening continues without a trap.
- R8: The first source is screened before the second. After a trap on the first source, the second source changes nothing.
- R9: When the two-source select is low, the second operand has no effect.
- R10: The result appears on the clock edge after the valid strobe. Exactly one of pass and trap pulses for one cycle per accepted operation, and neither pulses without one. The control/status output holds its value between operations.
- R11: Zero, normal and infinite operands set no cause bit and raise no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| dbl_i | input | 1 | 1 = double precision, 0 = single |
| two_src_i | input | 1 | 1 = second source is used |
| src_a_i | input | 64 | First source operand |
| src_b_i | input | 64 | Second source operand |
| csr_i | input | 32 | Current control/status word |
| csr_o | output | 32 | Updated control/status word |
| trap_o | output | 1 | Exception request, one-cycle pulse |
| pass_o | output | 1 | Operation may proceed, one-cycle pulse |

## Verification
The non-trapping quiet-NaN path and an unconditional trap can both fire within one operation. This happens when the first source is a quiet NaN with the invalid enable clear and the second source is subnormal or a signaling NaN. The bench provokes exactly that case. It expects both cause bits, the invalid sticky flag and a trap all at once. The reverse order, with a trapping first source, must show only the first source's effect. Operations are also issued on back-to-back cycles, so that each result must line up with its own stimulus.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int CSR_W     = 32;
  localparam int OPND_W    = 64;
  localparam int N_SRC     = 2;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int SP_MAG_W  = SP_EXP_W + SP_FRAC_W;
  localparam int DP_MAG_W  = DP_EXP_W + DP_FRAC_W;

  // control/status field positions (decoded by neighbours)
  localparam int FLG_V   = 6;
  localparam int EN_V    = 11;
  localparam int CAU_LSB = 12;
  localparam int CAU_MSB = 17;
  localparam int CAU_V   = 16;
  localparam int CAU_E   = 17;

  typedef enum logic [2:0] {
    CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_QNAN, CL_SNAN
  } opnd_class_e;
endpackage

// File: rtl/fpsc_classify.sv
module fpsc_classify
  import fpsc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W-1:0] mag_i,
  output opnd_class_e             cls_o
);
  localparam int MAG_W = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones, exp_zero, frac_nz;

  assign exp_f    = mag_i[MAG_W-1:FRAC_W];
  assign frac_f   = mag_i[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    if (exp_zero)      cls_o = frac_nz ? CL_SUB : CL_ZERO;
    else if (exp_ones) cls_o = !frac_nz ? CL_INF :
                               (frac_f[FRAC_W-1] ? CL_QNAN : CL_SNAN);
    else               cls_o = CL_NORM;
  end
endmodule

// File: rtl/fpsc_step.sv
module fpsc_step
  import fpsc_pkg::*;
(
  input  logic             active_i,
  input  logic             stop_i,
  input  opnd_class_e      cls_i,
  input  logic [CSR_W-1:0] csr_i,
  output logic [CSR_W-1:0] csr_o,
  output logic             trap_o
);
  always_comb begin
    csr_o  = csr_i;
    trap_o = stop_i;
    if (active_i && !stop_i) begin
      unique case (cls_i)
        CL_SUB, CL_SNAN: begin
          csr_o[CAU_E] = 1'b1;
          trap_o       = 1'b1;
        end
        CL_QNAN: begin
          csr_o[CAU_V] = 1'b1;
          if (csr_i[EN_V]) trap_o = 1'b1;
          else             csr_o[FLG_V] = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fpu_opnd_screen.sv
module fpu_opnd_screen
  import fpsc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              dbl_i,
  input  logic              two_src_i,
  input  logic [OPND_W-1:0] src_a_i,
  input  logic [OPND_W-1:0] src_b_i,
  input  logic [CSR_W-1:0]  csr_i,
  output logic [CSR_W-1:0]  csr_o,
  output logic              trap_o,
  output logic              pass_o
);
  logic [OPND_W-1:0] src   [N_SRC];
  logic              act   [N_SRC];
  opnd_class_e       cls   [N_SRC];
  logic [CSR_W-1:0]  csr_c [N_SRC+1];
  logic              trp_c [N_SRC+1];

  assign src[0] = src_a_i;
  assign src[1] = src_b_i;
  assign act[0] = 1'b1;
  assign act[1] = two_src_i;

  always_comb begin
    csr_c[0] = csr_i;
    csr_c[0][CAU_MSB:CAU_LSB] = '0;
  end
  assign trp_c[0] = 1'b0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    opnd_class_e cls_sp, cls_dp;

    fpsc_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_cls_sp (
      .mag_i (src[g][SP_MAG_W-1:0]),
      .cls_o (cls_sp)
    );
    fpsc_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_cls_dp (
      .mag_i (src[g][DP_MAG_W-1:0]),
      .cls_o (cls_dp)
    );
    assign cls[g] = dbl_i ? cls_dp : cls_sp;

    // sources screened in order; an earlier trap blocks later ones
    fpsc_step u_step (
      .active_i (act[g]),
      .stop_i   (trp_c[g]),
      .cls_i    (cls[g]),
      .csr_i    (csr_c[g]),
      .csr_o    (csr_c[g+1]),
      .trap_o   (trp_c[g+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_o  <= '0;
      trap_o <= 1'b0;
      pass_o <= 1'b0;
    end else if (valid_i) begin
      csr_o  <= csr_c[N_SRC];
      trap_o <= trp_c[N_SRC];
      pass_o <= !trp_c[N_SRC];
    end else begin
      trap_o <= 1'b0;
      pass_o <= 1'b0;
    end
  end

  AST_PASS_TRAP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && trap_o)); // R10
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (pass_o ^ trap_o)); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!pass_o && !trap_o)); // R10
  AST_CSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(csr_o)); // R10
  AST_KEEP_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (csr_o[FLG_V-1:0] == $past(csr_i[FLG_V-1:0]) &&
                 csr_o[CAU_LSB-1:FLG_V+1] == $past(csr_i[CAU_LSB-1:FLG_V+1]) &&
                 csr_o[CSR_W-1:CAU_MSB+1] == $past(csr_i[CSR_W-1:CAU_MSB+1]))); // R3
  AST_CAUSE_LOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> csr_o[CAU_V-1:CAU_LSB] == '0); // R3
  AST_TRAP_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (csr_o[CAU_E] || csr_o[CAU_V])); // R5
  AST_PASS_NO_UNIMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> !csr_o[CAU_E]); // R4
  AST_VTRAP_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !csr_o[CAU_E]) |-> csr_o[EN_V]); // R6
  AST_PASS_V_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o && csr_o[CAU_V]) |-> csr_o[FLG_V]); // R7
endmodule

// File: tb/fpu_opnd_screen_test.sv
module fpu_opnd_screen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, dbl = 1'b0, two = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic [31:0] csr_in = '0;
  logic [31:0] csr_out;
  logic        trap, pass;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] csr;
    logic        trap;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  fpu_opnd_screen uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .dbl_i(dbl),
    .two_src_i(two), .src_a_i(a), .src_b_i(b), .csr_i(csr_in),
    .csr_o(csr_out), .trap_o(trap), .pass_o(pass)
  );

  // 0 = harmless, 1 = unimplemented (sub/sNaN), 2 = quiet NaN
  function automatic int kind(logic d, logic [63:0] v);
    logic ones, zero, fnz, qb;
    if (d) begin
      ones = (v[62:52] == 11'h7ff); zero = (v[62:52] == 0);
      fnz = (v[51:0] != 0); qb = v[51];
    end else begin
      ones = (v[30:23] == 8'hff); zero = (v[30:23] == 0);
      fnz = (v[22:0] != 0); qb = v[22];
    end
    if (zero && fnz) return 1;
    if (ones && fnz) return qb ? 2 : 1;
    return 0;
  endfunction

  function automatic exp_t model(logic d, logic t, logic [63:0] x, logic [63:0] y,
                                 logic [31:0] c, string tag);
    exp_t e;
    int   k;
    e.csr = c & ~32'h0003_f000;
    e.trap = 1'b0;
    e.tag = tag;
    for (int i = 0; i < 2; i++) begin
      if (i == 1 && !t) break;
      if (e.trap) break;
      k = kind(d, i == 0 ? x : y);
      if (k == 1) begin
        e.csr[17] = 1'b1; e.trap = 1'b1;
      end else if (k == 2) begin
        e.csr[16] = 1'b1;
        if (c[11]) e.trap = 1'b1;
        else e.csr[6] = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic op(logic d, logic t, logic [63:0] x, logic [63:0] y,
                    logic [31:0] c, string tag);
    @(negedge clk);
    valid = 1'b1; dbl = d; two = t; a = x; b = y; csr_in = c;
    q.push_back(model(d, t, x, y, c, tag));
  endtask

  task automatic idle(int n);
    @(negedge clk);
    valid = 1'b0;
    a = '1; b = '1; csr_in = '1;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each result against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && (pass || trap)) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected result: trap=%0b pass=%0b expected none", trap, pass);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (csr_out !== e.csr || trap !== e.trap || pass !== !e.trap) begin
          errors++;
          $display("FAIL %s csr=%h trap=%0b pass=%0b expected csr=%h trap=%0b pass=%0b",
                   e.tag, csr_out, trap, pass, e.csr, e.trap, !e.trap);
        end
      end
    end
  end

  localparam logic [31:0] C_NOV = 32'h8103_f7bd; // invalid enable clear
  localparam logic [31:0] C_V   = 32'h8103_ffbd; // invalid enable set
  localparam logic [63:0] S_ONE = 64'h3f80_0000, S_INF = 64'h7f80_0000,
                          S_SUB = 64'h0000_0001, S_SN = 64'h7f80_0001,
                          S_QN  = 64'h7fc0_0000, S_SN2 = 64'h7fa0_0000;
  localparam logic [63:0] D_ONE = 64'h3ff0_0000_0000_0000, D_INF = 64'h7ff0_0000_0000_0000,
                          D_SUB = 64'h0000_0000_0000_0001, D_SN = 64'h7ff0_0000_0000_0001,
                          D_QN  = 64'h7ff8_0000_0000_0000, D_SN2 = 64'h7ff4_0000_0000_0000;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (csr_out !== 32'h0 || trap !== 1'b0 || pass !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset csr=%h trap=%0b pass=%0b expected 0 0 0", csr_out, trap, pass);
    end

    // back-to-back stream
    op(0, 1, S_ONE, 64'h0, C_NOV, "R11 single normal+zero");
    op(1, 1, D_INF, D_ONE, C_V, "R11 double inf+normal");
    op(0, 1, S_SUB, S_ONE, 32'h0, "R4 single subnormal, enables off");
    op(1, 1, D_ONE, D_SUB, 32'h0, "R4 double subnormal second");
    op(0, 1, S_SN, S_ONE, C_NOV, "R5 single sNaN");
    op(1, 1, D_ONE, D_SN, C_NOV, "R5 double sNaN second");
    op(0, 1, S_QN, S_ONE, C_V, "R6 single qNaN enabled");
    op(0, 1, S_ONE, S_QN, C_NOV, "R7 single qNaN not enabled");
    op(1, 1, D_QN, D_QN, C_NOV, "R7 double qNaN both");
    op(1, 1, D_QN, D_SN, C_V, "R8 qNaN trap first hides sNaN");
    op(0, 1, S_SN, S_QN, C_NOV, "R8 sNaN first hides qNaN flag");
    op(0, 1, S_QN, S_SUB, C_NOV, "R7 R8 qNaN flag plus subnormal trap");
    idle(2);
    checks++;
    if (csr_out !== q.size() + 32'h8103_f07d || trap || pass) begin
      // last result: C_NOV cause cleared, V+E cause, flag V
      if (!(csr_out === 32'h8103_07fd && !trap && !pass)) begin
        errors++;
        $display("FAIL R10 hold csr=%h trap=%0b pass=%0b expected csr=%h 0 0",
                 csr_out, trap, pass, 32'h8103_07fd);
      end
    end

    op(0, 0, S_ONE, S_SN, C_NOV, "R9 one source ignores sNaN");
    idle(1);
    op(0, 0, S_ONE, S_QN, C_NOV, "R9 one source ignores qNaN");
    idle(1);
    op(0, 1, {32'h7ff0_0000, 32'h3f80_0000}, {32'hffff_ffff, 32'h0}, C_V,
       "R1 single ignores upper half");
    op(0, 1, D_SN, S_ONE, C_NOV, "R1 single sees low word subnormal");
    op(0, 1, S_SN2, S_ONE, C_V, "R1 single bit22 clear is signaling");
    op(1, 1, 64'h3ff0_0000_7f80_0001, D_ONE, C_NOV, "R2 double normal, sNaN-like low word");
    op(1, 1, D_SN2, D_ONE, C_V, "R2 double bit51 clear is signaling");
    op(1, 1, D_ONE, 64'h8000_0000_0000_0000, 32'h0003_f000, "R3 stale cause cleared");
    idle(3);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing results: actual pending=%0d expected 0", q.size());
    end
    report();
  end
endmodule